// File: doc/BRIEF.md
# Proportional-Kick Pump Loop Filter

This block is the digital loop filter of a phase-locked loop. It receives the raise and lower pulses produced by a phase-frequency detector. It turns them into a signed control word for a numerically controlled oscillator. A signed integrator register moves by a fixed step on each clock cycle in which exactly one pulse is active, and it holds in every other cycle. The control word is this integrator plus a proportional kick. The kick is an offset that is present only while a single pulse is active: positive for raise, negative for lower. It stands in for the resistor in series with the filter capacitor, and it lets the loop correct frequency quickly once the phases meet, so the loop does not hunt.

The step size, the kick size and the centre value are sampled while reset is held. The centre value is the integrator start point, which matches the nominal oscillator frequency. Changes to these inputs during operation have no effect until the next reset. The integrator and the output word saturate at the signed limits instead of wrapping around. The pulse inputs and the output are plain level signals with no handshake: the detector drives the pulse pins every cycle and the oscillator takes the control word every cycle, so back-pressure does not apply. The output is registered and reflects the pulses one cycle after they are sampled.

Top module: `cp_loop_filter`

## Requirements
- R1: While reset is asserted at a clock edge, the integrator and the output word are loaded with centre_in, and rate_in and kick_in are captured.
- R2: On a clock edge where pump_up=1 and pump_dn=0, the integrator increases by the captured rate.
- R3: On a clock edge where pump_dn=1 and pump_up=0, the integrator decreases by the captured rate.
- R4: On a clock edge where pump_up and pump_dn are equal (both 0 or both 1), the integrator keeps its value, and the output equals the integrator with no offset.
- R5: On an edge with only pump_up=1, the output becomes the updated integrator plus the captured kick. With only pump_dn=1 it becomes the updated integrator minus the kick.
- R6: The kick is gone on the first edge at which the pulse is no longer the only active one.
- R7: The integrator saturates at +(2^(W-1)-1) and -2^(W-1) and never wraps.
- R8: The output word (integrator plus kick) saturates at the same signed limits.
- R9: Changes to rate_in, kick_in and centre_in while reset is low have no effect on the output.
- R10: The output is registered. A change on the pulse inputs shows on ctrl_out after exactly one rising clock edge and not earlier.
- R11: With a captured kick of zero, the output always equals the integrator (pure integrator mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; also the configuration capture window |
| pump_up | input | 1 | Raise pulse from the phase detector |
| pump_dn | input | 1 | Lower pulse from the phase detector |
| rate_in | input | RATE_W | Unsigned integrator step per cycle, captured during reset |
| kick_in | input | KICK_W | Unsigned proportional kick size, captured during reset |
| centre_in | input | W | Signed integrator start value, loaded during reset |
| ctrl_out | output | W | Signed saturated oscillator control word |

## Verification
The bench targets the positive and negative rails. There, a design that wraps instead of clamping would jump from one end of the range to the other, either in the integrator or only in the kicked output word. It drives both pulses high at once: a design that does not decode this case as hold would ramp the integrator or apply a kick. It changes the rate and kick inputs during operation: a design that samples them outside reset would change its slope part-way through a run. It also checks zero kick, the cycle when the kick ends, and the exact one-edge latency, which catch a kick that lingers or an output that is combinational or arrives a cycle late.

// File: rtl/pump_pkg.sv
package pump_pkg;

  // Net pump action decoded from the detector pulses
  typedef enum logic [1:0] {
    PUMP_IDLE  = 2'd0,
    PUMP_RAISE = 2'd1,
    PUMP_LOWER = 2'd2
  } pump_dir_e;

endpackage

// File: rtl/pump_dir_decode.sv
module pump_dir_decode
  import pump_pkg::*;
(
  input  logic      up_i,
  input  logic      dn_i,
  output pump_dir_e dir_o
);

  // Equal pulses cancel: the pump drives nothing
  always_comb begin
    unique case ({up_i, dn_i})
      2'b10:   dir_o = PUMP_RAISE;
      2'b01:   dir_o = PUMP_LOWER;
      default: dir_o = PUMP_IDLE;
    endcase
  end

endmodule

// File: rtl/pump_cfg_hold.sv
module pump_cfg_hold #(
  parameter int RATE_W = 12,
  parameter int KICK_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [KICK_W-1:0] kick_i,
  output logic [RATE_W-1:0] rate_q,
  output logic [KICK_W-1:0] kick_q
);

  // Capture only inside the reset window; frozen during operation
  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q <= rate_i;
      kick_q <= kick_i;
    end
  end

endmodule

// File: rtl/pump_sat_add.sv
module pump_sat_add
  import pump_pkg::*;
#(
  parameter int W     = 16,
  parameter int MAG_W = 12
) (
  input  logic signed [W-1:0] base_i,
  input  logic [MAG_W-1:0]    mag_i,
  input  pump_dir_e           dir_i,
  output logic signed [W-1:0] sum_o
);

  localparam int EXT_W = ((W > MAG_W) ? W : MAG_W) + 2;
  localparam logic signed [EXT_W-1:0] MAX_X =
    {{(EXT_W-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [EXT_W-1:0] MIN_X =
    {{(EXT_W-W+1){1'b1}}, {(W-1){1'b0}}};

  logic signed [EXT_W-1:0] base_x;
  logic signed [EXT_W-1:0] mag_x;
  logic signed [EXT_W-1:0] raw_x;

  assign base_x = {{(EXT_W-W){base_i[W-1]}}, base_i};
  assign mag_x  = {{(EXT_W-MAG_W){1'b0}}, mag_i};

  always_comb begin
    unique case (dir_i)
      PUMP_RAISE: raw_x = base_x + mag_x;
      PUMP_LOWER: raw_x = base_x - mag_x;
      default:    raw_x = base_x;
    endcase
  end

  // Clamp to the signed range of W bits
  always_comb begin
    if (raw_x > MAX_X)      sum_o = MAX_X[W-1:0];
    else if (raw_x < MIN_X) sum_o = MIN_X[W-1:0];
    else                    sum_o = raw_x[W-1:0];
  end

endmodule

// File: rtl/cp_loop_filter.sv
module cp_loop_filter
  import pump_pkg::*;
#(
  parameter int W      = 16,
  parameter int RATE_W = 12,
  parameter int KICK_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pump_up,
  input  logic                pump_dn,
  input  logic [RATE_W-1:0]   rate_in,
  input  logic [KICK_W-1:0]   kick_in,
  input  logic signed [W-1:0] centre_in,
  output logic signed [W-1:0] ctrl_out
);

  pump_dir_e           dir;
  logic [RATE_W-1:0]   rate_q;
  logic [KICK_W-1:0]   kick_q;
  logic signed [W-1:0] integ_q;
  logic signed [W-1:0] integ_d;
  logic signed [W-1:0] ctrl_d;

  pump_dir_decode u_dir (
    .up_i  (pump_up),
    .dn_i  (pump_dn),
    .dir_o (dir)
  );

  pump_cfg_hold #(
    .RATE_W (RATE_W),
    .KICK_W (KICK_W)
  ) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .rate_i (rate_in),
    .kick_i (kick_in),
    .rate_q (rate_q),
    .kick_q (kick_q)
  );

  // Integral path: fixed-slope ramp
  pump_sat_add #(
    .W     (W),
    .MAG_W (RATE_W)
  ) u_ramp (
    .base_i (integ_q),
    .mag_i  (rate_q),
    .dir_i  (dir),
    .sum_o  (integ_d)
  );

  // Proportional path: kick on top of the updated integrator
  pump_sat_add #(
    .W     (W),
    .MAG_W (KICK_W)
  ) u_kick (
    .base_i (integ_d),
    .mag_i  (kick_q),
    .dir_i  (dir),
    .sum_o  (ctrl_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      integ_q  <= centre_in;
      ctrl_out <= centre_in;
    end else begin
      integ_q  <= integ_d;
      ctrl_out <= ctrl_d;
    end
  end

endmodule

// File: rtl/pump_loop_checker.sv
module pump_loop_checker #(
  parameter int W      = 16,
  parameter int RATE_W = 12
) (
  input logic                clk,
  input logic                rst,
  input logic                up,
  input logic                dn,
  input logic signed [W-1:0] integ,
  input logic signed [W-1:0] ctrl,
  input logic [RATE_W-1:0]   rate_q
);

  AST_UP_RISES: assert property (@(posedge clk) disable iff (rst)
    (up && !dn) |=> (integ >= $past(integ))); // R2

  AST_DN_FALLS: assert property (@(posedge clk) disable iff (rst)
    (dn && !up) |=> (integ <= $past(integ))); // R3

  AST_HOLD_STILL: assert property (@(posedge clk) disable iff (rst)
    (up == dn) |=> $stable(integ)); // R4

  AST_HOLD_NO_KICK: assert property (@(posedge clk) disable iff (rst)
    (up == dn) |=> (ctrl == integ)); // R6

  AST_KICK_UP: assert property (@(posedge clk) disable iff (rst)
    (up && !dn) |=> (ctrl >= integ)); // R5

  AST_KICK_DN: assert property (@(posedge clk) disable iff (rst)
    (dn && !up) |=> (ctrl <= integ)); // R5

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(rate_q)); // R9

endmodule

bind cp_loop_filter pump_loop_checker #(
  .W      (W),
  .RATE_W (RATE_W)
) u_pump_chk (
  .clk    (clk),
  .rst    (rst),
  .up     (pump_up),
  .dn     (pump_dn),
  .integ  (integ_q),
  .ctrl   (ctrl_out),
  .rate_q (rate_q)
);

// File: tb/cp_loop_filter_bench.sv
module cp_loop_filter_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W      = 16;
  localparam int RATE_W = 12;
  localparam int KICK_W = 12;
  localparam int MAXV   = (1 << (W-1)) - 1;
  localparam int MINV   = -(1 << (W-1));

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                pump_up = 1'b0;
  logic                pump_dn = 1'b0;
  logic [RATE_W-1:0]   rate_in = '0;
  logic [KICK_W-1:0]   kick_in = '0;
  logic signed [W-1:0] centre_in = '0;
  logic signed [W-1:0] ctrl_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Bench model state
  int m_int, m_rate, m_kick, m_exp;

  cp_loop_filter #(
    .W      (W),
    .RATE_W (RATE_W),
    .KICK_W (KICK_W)
  ) u_cp_loop_filter (
    .clk       (clk),
    .rst       (rst),
    .pump_up   (pump_up),
    .pump_dn   (pump_dn),
    .rate_in   (rate_in),
    .kick_in   (kick_in),
    .centre_in (centre_in),
    .ctrl_out  (ctrl_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int clamp(int v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return v;
  endfunction

  function automatic int sgn(bit u, bit d);
    if (u && !d) return 1;
    if (d && !u) return -1;
    return 0;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(int centre, int rate, int kick);
    @(negedge clk);
    rst       = 1'b1;
    centre_in = W'(centre);
    rate_in   = RATE_W'(rate);
    kick_in   = KICK_W'(kick);
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst    = 1'b0;
    m_int  = centre;
    m_rate = rate;
    m_kick = kick;
    m_exp  = centre;
    check("R1 reset load", int'(ctrl_out), m_exp);
  endtask

  // Drive one cycle at the falling edge, check at the next falling edge
  task automatic cycle(bit u, bit d, string tag);
    int s;
    pump_up = u;
    pump_dn = d;
    @(posedge clk);
    s     = sgn(u, d);
    m_int = clamp(m_int + s * m_rate);
    m_exp = clamp(m_int + s * m_kick);
    @(negedge clk);
    check(tag, int'(ctrl_out), m_exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd61937));

    // Directed: ramp, kick, kick removal
    do_reset(1000, 10, 50);
    cycle(1'b1, 1'b0, "R2 R5 up ramp with kick");
    check("R2 up step", int'(ctrl_out), 1000 + 10 + 50);
    cycle(1'b1, 1'b0, "R2 R5 second up");
    cycle(1'b0, 1'b0, "R6 R4 kick removed");
    check("R6 value", int'(ctrl_out), 1020);
    cycle(1'b0, 1'b1, "R3 R5 down with kick");
    check("R3 down step", int'(ctrl_out), 1010 - 50);
    cycle(1'b1, 1'b1, "R4 both high hold");
    check("R4 both", int'(ctrl_out), 1010);

    // R10: output does not move before the edge
    pump_up = 1'b1;
    pump_dn = 1'b0;
    #1;
    check("R10 no early change", int'(ctrl_out), 1010);
    cycle(1'b1, 1'b0, "R10 one edge latency");

    // R9: changing config during operation has no effect
    rate_in   = RATE_W'(500);
    kick_in   = KICK_W'(900);
    centre_in = W'(-3000);
    cycle(1'b1, 1'b0, "R9 config ignored up");
    cycle(1'b0, 1'b1, "R9 config ignored down");
    cycle(1'b0, 1'b0, "R9 config ignored hold");

    // R7 R8: top rail
    do_reset(MAXV - 150, 100, 300);
    cycle(1'b1, 1'b0, "R8 output clamp high");
    check("R8 high rail", int'(ctrl_out), MAXV);
    cycle(1'b1, 1'b0, "R7 integrator clamp high");
    cycle(1'b0, 1'b0, "R7 high hold");
    check("R7 high rail", int'(ctrl_out), MAXV);

    // R7 R8: bottom rail
    do_reset(MINV + 150, 100, 300);
    cycle(1'b0, 1'b1, "R8 output clamp low");
    check("R8 low rail", int'(ctrl_out), MINV);
    cycle(1'b0, 1'b1, "R7 integrator clamp low");
    cycle(1'b0, 1'b0, "R7 low hold");
    check("R7 low rail", int'(ctrl_out), MINV);

    // R11: zero kick is a pure integrator
    do_reset(-200, 7, 0);
    for (int i = 0; i < 20; i++) begin
      cycle(1'(i % 3 != 0), 1'(i % 5 == 0), "R11 pure integrator");
    end

    // Constrained random, with config churn and occasional resets
    for (int blk = 0; blk < 20; blk++) begin
      do_reset(int'($urandom_range(0, 65535)) - 32768,
               int'($urandom_range(0, (1 << RATE_W) - 1)),
               int'($urandom_range(0, (1 << KICK_W) - 1)));
      for (int i = 0; i < 300; i++) begin
        int r;
        r = int'($urandom_range(0, 3));
        rate_in   = RATE_W'($urandom);
        kick_in   = KICK_W'($urandom);
        centre_in = W'($urandom);
        cycle(r[0], r[1], "R2 R3 R4 R5 R7 R8 R9 random");
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule